// File: doc/BRIEF.md
# Masked Vector Element Execution Unit

This unit carries out one element-wise integer vector operation under a per-element predicate. For each element it reads a pair of operands from two source vector registers through a shared read port, then computes the sum, difference or low product. The result goes to a destination write port, and the write strobe is raised only for elements whose predicate bit is set. Elements whose bit is clear act as no-operations, so the destination keeps its old contents there. Only elements below the current vector length take part.

The predicate lives in a 32-bit mask register inside the unit. A set-all command makes every element active. A compare command walks the active length and sets each bit where the signed source element is greater than a scalar operand.

A mode input picks one of two schedules for execute commands. The plain schedule visits every element below the vector length and gates the write strobe with the mask bit. The density-time schedule visits only the elements whose mask bit is set, so its run time follows the number of active elements rather than the vector length. A single-cycle start pulse launches a command, and a single-cycle done pulse marks its end.

Top module: `vx_masked_exec`

## Requirements
- R1: After reset `wr_en_o` and `done_o` are low and `mask_o` is all ones.
- R2: `op_i` selects the element operation: 0 gives A+B, 1 gives A-B, 2 gives the low 32 bits of A*B, all in two's complement with wrap-around. `wr_data_o` carries the result for the element on `wr_idx_o`.
- R3: With `cmd_i`=0 (execute) and `dense_i`=0, elements 0 to VL-1 are visited in ascending order, one per cycle. A write is issued only where the mask bit is 1, and every other destination element keeps its value.
- R4: With `cmd_i`=0 and `dense_i`=1, only elements whose mask bit is 1 and whose index is below VL are issued. They are issued in ascending order, one write per cycle, with no cycle spent on skipped elements.
- R5: Let n be VL for the plain schedule and for compare, the number of active elements below VL for density-time, and 0 for set-all. Then `done_o` is high for exactly one cycle, after the (n+1)-th rising edge that follows the edge accepting `start_i`. An all-zero mask in density-time mode therefore finishes two cycles after start with no write.
- R6: An element at or above VL is never written in either schedule, whatever its mask bit. A `vl_i` above 32 is treated as 32.
- R7: `cmd_i`=2 (set-all) sets all 32 mask bits to 1 at the edge that accepts the start. It writes no destination element.
- R8: `cmd_i`=1 (compare) sets mask bit i for i<VL to 1 when the signed `rd_a_i` element is greater than the signed `scalar_i`, and to 0 otherwise. It clears the bits at or above VL and writes no destination element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch pulse; taken only when idle |
| cmd_i | input | 2 | 0 execute, 1 compare, 2 set-all mask, 3 reserved (no action) |
| op_i | input | 2 | 0 add, 1 subtract, 2 multiply low |
| dense_i | input | 1 | 1 selects the density-time schedule |
| vl_i | input | 6 | Vector length, clamped to 32 |
| scalar_i | input | 32 | Scalar operand for compare |
| rd_idx_o | output | 5 | Element index for the source read port |
| rd_a_i | input | 32 | Element of source A at `rd_idx_o` |
| rd_b_i | input | 32 | Element of source B at `rd_idx_o` |
| wr_en_o | output | 1 | Destination write strobe |
| wr_idx_o | output | 5 | Destination element index |
| wr_data_o | output | 32 | Destination element data |
| done_o | output | 1 | End-of-command pulse |
| mask_o | output | 32 | Current mask register, bit i for element i |

## Verification
The hardest cases to reach are mask bits that are set above the vector length, and a mask with no set bit at all. Neither comes from a single command. The stimulus first sets every bit with set-all and then runs short-length execute commands in both schedules, to show that the elements above VL stay untouched. It then runs a compare against the largest positive scalar, which clears the mask, and follows it with a full-length density-time run that must finish in two cycles without writing.

// File: rtl/vx_pkg.sv
package vx_pkg;
  typedef enum logic [1:0] {OP_ADD = 2'd0, OP_SUB = 2'd1, OP_MUL = 2'd2, OP_RSV = 2'd3} op_e;
  typedef enum logic [1:0] {CMD_EXEC = 2'd0, CMD_CMP = 2'd1, CMD_SETM = 2'd2, CMD_RSV = 2'd3} cmd_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_RUN = 2'd1, ST_FIN = 2'd2} state_e;
endpackage

// File: rtl/vx_find_first.sv
module vx_find_first #(
  parameter int N  = 32,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic [IW-1:0] idx_o,
  output logic          found_o
);
  always_comb begin
    idx_o   = '0;
    found_o = |req_i;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/vx_alu.sv
module vx_alu
  import vx_pkg::*;
#(
  parameter int DW = 32
) (
  input  op_e           op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      OP_SUB:  res_o = a_i - b_i;
      OP_MUL:  res_o = a_i * b_i;
      default: res_o = a_i + b_i;
    endcase
  end
endmodule

// File: rtl/vx_mask_reg.sv
module vx_mask_reg #(
  parameter int N  = 32,
  localparam int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_all_i,
  input  logic          wipe_i,
  input  logic          upd_i,
  input  logic [IW-1:0] upd_idx_i,
  input  logic          upd_bit_i,
  output logic [N-1:0]  mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_o <= '1;
    else if (set_all_i) mask_o <= '1;
    else if (wipe_i)    mask_o <= '0;
    else if (upd_i)     mask_o[upd_idx_i] <= upd_bit_i;
  end

  // R7
  set_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_all_i |=> (&mask_o));
  // R8
  wipe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wipe_i && !set_all_i) |=> (mask_o == '0));
endmodule

// File: rtl/vx_masked_exec.sv
module vx_masked_exec
  import vx_pkg::*;
#(
  parameter int MAX_VL = 32,
  parameter int DW     = 32,
  localparam int IW    = $clog2(MAX_VL),
  localparam int LW    = IW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        cmd_i,
  input  logic [1:0]        op_i,
  input  logic              dense_i,
  input  logic [LW-1:0]     vl_i,
  input  logic [DW-1:0]     scalar_i,
  output logic [IW-1:0]     rd_idx_o,
  input  logic [DW-1:0]     rd_a_i,
  input  logic [DW-1:0]     rd_b_i,
  output logic              wr_en_o,
  output logic [IW-1:0]     wr_idx_o,
  output logic [DW-1:0]     wr_data_o,
  output logic              done_o,
  output logic [MAX_VL-1:0] mask_o
);
  state_e              state_q;
  cmd_e                cmd_q;
  op_e                 op_q;
  logic                dense_q;
  logic [LW-1:0]       vl_q;
  logic [DW-1:0]       scalar_q;
  logic [MAX_VL-1:0]   pending_q, pending_init, pending_next, len_mask;
  logic [LW-1:0]       vl_eff;
  logic [IW-1:0]       cur_idx;
  logic                cur_found, accept, issue, cmp_bit;
  logic [DW-1:0]       alu_res;
  cmd_e                cmd_in;

  assign cmd_in = cmd_e'(cmd_i);
  assign accept = start_i && (state_q == ST_IDLE);
  assign issue  = (state_q == ST_RUN);
  assign vl_eff = (vl_i > LW'(MAX_VL)) ? LW'(MAX_VL) : vl_i;

  for (genvar g = 0; g < MAX_VL; g++) begin : g_len
    assign len_mask[g] = (LW'(g) < vl_eff);
  end

  always_comb begin
    unique case (cmd_in)
      CMD_EXEC: pending_init = dense_i ? (len_mask & mask_o) : len_mask;
      CMD_CMP:  pending_init = len_mask;
      default:  pending_init = '0;
    endcase
  end

  // retire lowest pending element
  assign pending_next = pending_q & (pending_q - MAX_VL'(1));

  vx_find_first #(.N(MAX_VL)) u_ff (
    .req_i   (pending_q),
    .idx_o   (cur_idx),
    .found_o (cur_found)
  );

  vx_alu #(.DW(DW)) u_alu (
    .op_i  (op_q),
    .a_i   (rd_a_i),
    .b_i   (rd_b_i),
    .res_o (alu_res)
  );

  assign cmp_bit = $signed(rd_a_i) > $signed(scalar_q);

  vx_mask_reg #(.N(MAX_VL)) u_mask (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_all_i (accept && cmd_in == CMD_SETM),
    .wipe_i    (accept && cmd_in == CMD_CMP),
    .upd_i     (issue && cmd_q == CMD_CMP),
    .upd_idx_i (cur_idx),
    .upd_bit_i (cmp_bit),
    .mask_o    (mask_o)
  );

  assign rd_idx_o = cur_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cmd_q     <= CMD_EXEC;
      op_q      <= OP_ADD;
      dense_q   <= 1'b0;
      vl_q      <= '0;
      scalar_q  <= '0;
      pending_q <= '0;
      done_o    <= 1'b0;
    end else begin
      done_o <= (state_q == ST_FIN);
      unique case (state_q)
        ST_IDLE: if (accept) begin
          cmd_q     <= cmd_in;
          op_q      <= op_e'(op_i);
          dense_q   <= dense_i;
          vl_q      <= vl_eff;
          scalar_q  <= scalar_i;
          pending_q <= pending_init;
          state_q   <= (pending_init == '0) ? ST_FIN : ST_RUN;
        end
        ST_RUN: begin
          pending_q <= pending_next;
          if (pending_next == '0) state_q <= ST_FIN;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_o   <= 1'b0;
      wr_idx_o  <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= issue && (cmd_q == CMD_EXEC) && mask_o[cur_idx];
      if (issue) begin
        wr_idx_o  <= cur_idx;
        wr_data_o <= alu_res;
      end
    end
  end

  // R6
  wr_below_vl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (LW'(wr_idx_o) < vl_q));
  // R3
  wr_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> mask_o[wr_idx_o]);
  // R4
  dense_no_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue && cmd_q == CMD_EXEC && dense_q) |=> wr_en_o);
  // R4
  run_has_work_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue |-> cur_found);
  // R5
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R5
  done_after_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !wr_en_o);
endmodule

// File: tb/vx_masked_exec_tb_top.sv
`timescale 1ns/1ps
module vx_masked_exec_tb_top;
  localparam int N = 32;
  localparam int DW = 32;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk_i = ~clk_i;

  logic          start_i = 1'b0, dense_i = 1'b0;
  logic [1:0]    cmd_i = '0, op_i = '0;
  logic [5:0]    vl_i = '0;
  logic [DW-1:0] scalar_i = '0;
  logic [4:0]    rd_idx_o, wr_idx_o;
  logic [DW-1:0] rd_a_i, rd_b_i, wr_data_o;
  logic          wr_en_o, done_o;
  logic [N-1:0]  mask_o;

  logic [DW-1:0] va [N];
  logic [DW-1:0] vb [N];
  logic [DW-1:0] vd [N];
  logic [DW-1:0] exp_vd [N];
  logic [N-1:0]  exp_mask;

  assign rd_a_i = va[rd_idx_o];
  assign rd_b_i = vb[rd_idx_o];

  vx_masked_exec dut_i (
    .clk_i, .rst_ni, .start_i, .cmd_i, .op_i, .dense_i, .vl_i, .scalar_i,
    .rd_idx_o, .rd_a_i, .rd_b_i, .wr_en_o, .wr_idx_o, .wr_data_o,
    .done_o, .mask_o
  );

  typedef struct { int idx; logic [DW-1:0] data; } wr_t;
  wr_t   sb_q[$];
  int    errors = 0, checks = 0, cyc = 0, exp_done_cyc = 0;
  bit    done_seen = 0;
  string cur_req = "R3";

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: pops scoreboard on every write, checks done timing
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (wr_en_o) begin
        if (sb_q.size() == 0) begin
          check(0, cur_req, "unexpected write idx", wr_idx_o, -1);
        end else begin
          wr_t e;
          e = sb_q.pop_front();
          check(int'(wr_idx_o) == e.idx, cur_req, "write index", wr_idx_o, e.idx);
          check(wr_data_o == e.data, "R2", "write data", wr_data_o, e.data);
        end
        vd[wr_idx_o] = wr_data_o;
      end
      if (done_o) begin
        done_seen = 1;
        check(cyc == exp_done_cyc, "R5", "done cycle", cyc, exp_done_cyc);
      end
    end
  end

  function automatic logic [DW-1:0] model_op(logic [1:0] op, logic [DW-1:0] a, logic [DW-1:0] b);
    case (op)
      2'd1:    return a - b;
      2'd2:    return a * b;
      default: return a + b;
    endcase
  endfunction

  // driver: builds expected writes, mask and timing, then launches
  task automatic run(logic [1:0] cmd, logic [1:0] op, logic dense, int vl,
                     logic [DW-1:0] scalar, string req);
    int vle, n;
    vle = (vl > N) ? N : vl;
    n = 0;
    if (cmd == 2'd0) begin
      for (int i = 0; i < vle; i++) begin
        if (exp_mask[i]) begin
          wr_t e;
          e.idx = i;
          e.data = model_op(op, va[i], vb[i]);
          sb_q.push_back(e);
          exp_vd[i] = e.data;
          n++;
        end
      end
      if (!dense) n = vle;
    end else if (cmd == 2'd1) begin
      n = vle;
      for (int i = 0; i < N; i++)
        exp_mask[i] = (i < vle) && ($signed(va[i]) > $signed(scalar));
    end else if (cmd == 2'd2) begin
      exp_mask = '1;
    end
    cur_req = req;
    done_seen = 0;
    @(negedge clk_i);
    cmd_i = cmd; op_i = op; dense_i = dense; vl_i = 6'(vl); scalar_i = scalar;
    start_i = 1'b1;
    exp_done_cyc = cyc + n + 2;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int t = 0; t < n + 8 && !done_seen; t++) @(negedge clk_i);
    check(done_seen, "R5", "done seen", done_seen, 1);
    check(sb_q.size() == 0, req, "writes missing", sb_q.size(), 0);
    sb_q.delete();
    begin
      int bad;
      bad = -1;
      for (int i = N - 1; i >= 0; i--) if (vd[i] !== exp_vd[i]) bad = i;
      check(bad < 0, "R6", "untouched destination", bad, -1);
    end
    check(mask_o == exp_mask, (cmd == 2'd1) ? "R8" : "R7", "mask", mask_o, exp_mask);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      va[i] = 32'(i * 1103 - 17000);
      vb[i] = 32'(i * i * 7 - 95);
      vd[i] = 32'hdead_0000 + 32'(i);
      exp_vd[i] = vd[i];
    end
    va[5] = 32'h7fff_ffff;
    va[9] = 32'h8000_0000;
    va[30] = 32'(40);
    exp_mask = '1;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    check(!wr_en_o, "R1", "wr_en after reset", wr_en_o, 0);
    check(!done_o, "R1", "done after reset", done_o, 0);
    check(mask_o == '1, "R1", "mask after reset", mask_o, 32'hffff_ffff);

    run(2'd2, 2'd0, 1'b0, 32, 0, "R7");                  // set-all
    run(2'd0, 2'd0, 1'b0, 32, 0, "R3");                  // plain add, full mask
    run(2'd1, 2'd0, 1'b0, 20, 32'(-3000), "R8");         // compare, mixed mask
    run(2'd0, 2'd1, 1'b0, 20, 0, "R3");                  // plain sub under mask
    run(2'd0, 2'd2, 1'b1, 20, 0, "R4");                  // dense mul under mask
    run(2'd0, 2'd0, 1'b1, 32, 0, "R4");                  // dense, bits above 20 clear
    run(2'd2, 2'd0, 1'b0, 0, 0, "R7");
    run(2'd0, 2'd1, 1'b1, 5, 0, "R6");                   // mask bits set above VL
    run(2'd0, 2'd2, 1'b0, 7, 0, "R6");
    run(2'd1, 2'd0, 1'b0, 32, 32'h7fff_ffff, "R8");      // all-zero mask
    run(2'd0, 2'd0, 1'b1, 32, 0, "R5");                  // dense, zero active: two cycles
    run(2'd0, 2'd0, 1'b0, 32, 0, "R3");                  // plain, nothing written
    run(2'd2, 2'd0, 1'b0, 0, 0, "R7");
    run(2'd0, 2'd1, 1'b0, 40, 0, "R6");                  // VL above maximum clamps
    run(2'd0, 2'd0, 1'b0, 0, 0, "R5");                   // VL zero
    run(2'd1, 2'd0, 1'b1, 31, 32'(-17000), "R8");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule